// File: doc/BRIEF.md
# Multicycle Load/Store Register-Machine Core

This block is a small 32-bit processor core that runs a reduced register-machine instruction set. The set covers word loads and stores, instructions that load a computed address into a register, and a register-to-register add. The core holds 32 general registers of 32 bits, a program counter, an instruction register and a run flag. Each instruction takes several cycles. The core reads the instruction word at the program counter, advances the counter by 4, decodes fixed fields and then carries out the operation. Loads and stores take one more memory transaction.

All memory traffic uses a single word port with a request/complete handshake. The core raises a request with an address, a write enable and write data, and holds all of them until the memory returns a one-cycle completion pulse. Read data must be valid alongside that pulse. After reset the core sits halted. A start pulse sets it running from the current program counter, and a stop instruction halts it again.

Top module: `lsc_core`

## Requirements
- R1: After reset, `running` is low and `mem_req` is low. The first instruction fetch after a start reads byte address 0.
- R2: While halted, a `start` high at a clock edge sets `running` and raises a fetch request in the following cycle.
- R3: Every fetch is a read (`mem_we` low) at the program counter. Instructions are fetched at consecutive addresses 4 apart.
- R4: The field layout is op = IR[31:27], ra = IR[26:22], rb = IR[21:17], rc = IR[16:12], c2 = IR[16:0] and c1 = IR[21:0]. Opcode 1 loads R[ra] from the word at R[rb] + sign-extended c2.
- R5: In displacement addressing (opcodes 1, 3, 5), an rb field of 0 selects a base of zero, whatever register 0 holds.
- R6: Opcodes 2 (load) and 6 (address-load) use the relative address. It is the already incremented PC plus sign-extended c1.
- R7: Opcode 3 stores R[ra] at the displacement address, and opcode 4 stores it at the relative address. Both do so with a write request.
- R8: Opcode 5 writes the displacement address into R[ra], and opcode 6 writes the relative address into R[ra]. Neither makes a memory access.
- R9: Opcode 12 writes R[rb] + R[rc] (modulo 2^32) into R[ra].
- R10: Opcode 31 clears `running`, and no request follows. A later start resumes fetching at the word after the stop.
- R11: Opcode 0 and every opcode not named above change no register and make no memory access. The next fetch follows directly.
- R12: A request keeps its address, write enable and write data steady until `mem_done`, and the core waits as long as the memory takes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, acted on while halted |
| running | output | 1 | Run flag |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_done` |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory raises `mem_done` only while a request is pending, and for a single cycle per transaction. A request that stays high without completion is then the core waiting, and its address and data must not move. The bench memory model keeps to this. It answers only a pending request, after a chosen wait of zero to three cycles, and it always drops the pulse in the next cycle. `start` is driven as a one-cycle pulse and only while the core is halted.

// File: rtl/lsc_pkg.sv
`timescale 1ns/1ps
package lsc_pkg;
   localparam logic [4:0] OPC_NOP  = 5'd0;
   localparam logic [4:0] OPC_LD   = 5'd1;
   localparam logic [4:0] OPC_LDR  = 5'd2;
   localparam logic [4:0] OPC_ST   = 5'd3;
   localparam logic [4:0] OPC_STR  = 5'd4;
   localparam logic [4:0] OPC_LA   = 5'd5;
   localparam logic [4:0] OPC_LAR  = 5'd6;
   localparam logic [4:0] OPC_ADD  = 5'd12;
   localparam logic [4:0] OPC_STOP = 5'd31;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_EXEC  = 2'd2,
      ST_MEM   = 2'd3
   } core_state_e;
endpackage

// File: rtl/lsc_regfile.sv
`timescale 1ns/1ps
module lsc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [$clog2(NREG)-1:0] wr_idx,
   input  logic [XLEN-1:0]         wr_val,
   input  logic [$clog2(NREG)-1:0] rd_idx_a,
   input  logic [$clog2(NREG)-1:0] rd_idx_b,
   input  logic [$clog2(NREG)-1:0] rd_idx_c,
   output logic [XLEN-1:0]         rd_val_a,
   output logic [XLEN-1:0]         rd_val_b,
   output logic [XLEN-1:0]         rd_val_c
);
   localparam int IDXW = $clog2(NREG);

   generate
      if ((1 << IDXW) != NREG) begin : g_bad_depth
         $error("lsc_regfile: NREG must be a power of two");
      end
   endgenerate

   logic [XLEN-1:0] bank [NREG];

   always_ff @(posedge clk) begin
      if (wr_en) bank[wr_idx] <= wr_val;
   end

   assign rd_val_a = bank[rd_idx_a];
   assign rd_val_b = bank[rd_idx_b];
   assign rd_val_c = bank[rd_idx_c];
endmodule

// File: rtl/lsc_agen.sv
`timescale 1ns/1ps
module lsc_agen #(
   parameter int XLEN = 32,
   parameter int LONGW = 22,
   parameter int SHORTW = 17,
   parameter int BASEW = 5
) (
   input  logic [XLEN-1:0]  pc_next,
   input  logic [XLEN-1:0]  base_val,
   input  logic [LONGW-1:0] imm_long,
   output logic [XLEN-1:0]  disp_addr,
   output logic [XLEN-1:0]  rel_addr
);
   generate
      if (SHORTW + BASEW != LONGW) begin : g_bad_fields
         $error("lsc_agen: base field must sit directly above the short immediate");
      end
      if (LONGW >= XLEN) begin : g_bad_width
         $error("lsc_agen: immediate wider than datapath");
      end
   endgenerate

   logic [BASEW-1:0]  base_sel;
   logic [SHORTW-1:0] imm_short;
   logic [XLEN-1:0]   base_eff;

   assign base_sel  = imm_long[LONGW-1 -: BASEW];
   assign imm_short = imm_long[SHORTW-1:0];
   assign base_eff  = (base_sel == '0) ? '0 : base_val;

   assign disp_addr = base_eff + {{(XLEN-SHORTW){imm_short[SHORTW-1]}}, imm_short};
   assign rel_addr  = pc_next + {{(XLEN-LONGW){imm_long[LONGW-1]}}, imm_long};
endmodule

// File: rtl/lsc_core.sv
`timescale 1ns/1ps
module lsc_core
   import lsc_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic            running,
   output logic            mem_req,
   output logic            mem_we,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   input  logic            mem_done
);
   localparam int RIDX   = $clog2(NREG);
   localparam int STEP   = XLEN / 8;
   localparam int LONGW  = 22;
   localparam int SHORTW = 17;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("lsc_core: instruction layout needs XLEN of 32");
      end
      if (NREG != 32) begin : g_bad_nreg
         $error("lsc_core: register fields are 5 bits, NREG must be 32");
      end
   endgenerate

   core_state_e     state;
   logic            run_q;
   logic [XLEN-1:0] pc_q, ir_q, ea_q;

   logic [4:0]      op;
   logic [RIDX-1:0] f_ra, f_rb, f_rc;
   assign op   = ir_q[31:27];
   assign f_ra = ir_q[26:22];
   assign f_rb = ir_q[21:17];
   assign f_rc = ir_q[16:12];

   logic is_load, is_store, is_rel, is_aload, is_add, is_stop, is_mem, is_known;
   always_comb begin
      is_load  = (op == OPC_LD)  || (op == OPC_LDR);
      is_store = (op == OPC_ST)  || (op == OPC_STR);
      is_aload = (op == OPC_LA)  || (op == OPC_LAR);
      is_rel   = (op == OPC_LDR) || (op == OPC_STR) || (op == OPC_LAR);
      is_add   = (op == OPC_ADD);
      is_stop  = (op == OPC_STOP);
      is_mem   = is_load || is_store;
      is_known = is_mem || is_aload || is_add || is_stop;
   end

   logic [XLEN-1:0] rs_a, rs_b, rs_c;
   logic [XLEN-1:0] disp_addr, rel_addr, eff_addr;
   logic            rf_we;
   logic [XLEN-1:0] rf_wval;

   lsc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk      (clk),
      .wr_en    (rf_we),
      .wr_idx   (f_ra),
      .wr_val   (rf_wval),
      .rd_idx_a (f_ra),
      .rd_idx_b (f_rb),
      .rd_idx_c (f_rc),
      .rd_val_a (rs_a),
      .rd_val_b (rs_b),
      .rd_val_c (rs_c)
   );

   lsc_agen #(.XLEN(XLEN), .LONGW(LONGW), .SHORTW(SHORTW), .BASEW(RIDX)) u_agen (
      .pc_next   (pc_q),
      .base_val  (rs_b),
      .imm_long  (ir_q[LONGW-1:0]),
      .disp_addr (disp_addr),
      .rel_addr  (rel_addr)
   );

   assign eff_addr = is_rel ? rel_addr : disp_addr;

   always_comb begin
      rf_we   = ((state == ST_EXEC) && (is_aload || is_add)) ||
                ((state == ST_MEM) && mem_done && is_load);
      if (state == ST_MEM)   rf_wval = mem_rdata;
      else if (is_add)       rf_wval = rs_b + rs_c;
      else                   rf_wval = eff_addr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         run_q <= 1'b0;
         pc_q  <= '0;
         ir_q  <= '0;
         ea_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               run_q <= 1'b1;
               state <= ST_FETCH;
            end
            ST_FETCH: if (mem_done) begin
               ir_q  <= mem_rdata;
               pc_q  <= pc_q + XLEN'(STEP);
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               if (is_mem) begin
                  ea_q  <= eff_addr;
                  state <= ST_MEM;
               end else if (is_stop) begin
                  run_q <= 1'b0;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_FETCH;
               end
            end
            ST_MEM: if (mem_done) state <= ST_FETCH;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign running   = run_q;
   assign mem_req   = (state == ST_FETCH) || (state == ST_MEM);
   assign mem_we    = (state == ST_MEM) && is_store;
   assign mem_addr  = (state == ST_MEM) ? ea_q : pc_q;
   assign mem_wdata = rs_a;

   AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !mem_req); // R1

   AST_RUN_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(start)); // R2

   AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |-> !mem_we); // R3

   AST_HALT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> $past(op == OPC_STOP)); // R10

   AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_EXEC) && !is_known) |=> (mem_req && !mem_we && (mem_addr == $past(pc_q)))); // R11

   AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12
endmodule

// File: tb/tb_lsc_core.sv
`timescale 1ns/1ps
module tb_lsc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        running, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_done = 1'b0;

   always #4 clk = ~clk;

   lsc_core dut (
      .clk(clk), .rst_n(rst_n), .start(start), .running(running),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   int tests = 0;
   int fails = 0;

   logic [31:0] mem [256];
   logic [31:0] log_addr [64];
   logic        log_we [64];
   int          nacc = 0;
   int          wcnt = 0;
   int          lat  = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_done = 1'b0;
         wcnt = 0;
      end else if (mem_done) begin
         mem_done = 1'b0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            wcnt = 0;
            mem_rdata = mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            if (nacc < 64) begin
               log_addr[nacc] = mem_addr;
               log_we[nacc]   = mem_we;
            end
            nacc++;
            mem_done = 1'b1;
         end else begin
            wcnt++;
         end
      end
   end

   localparam logic [31:0] STOPW = 32'hF800_0000;

   typedef struct packed {
      logic [31:0] i0, i1, i2, i3, i4;
      logic [31:0] chk;
      logic [31:0] expv;
      logic [7:0]  nacc;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{{5'd5,5'd1,5'd0,17'h40}, {5'd3,5'd1,5'd0,17'h300}, STOPW, STOPW, STOPW, 32'h300, 32'h40, 8'd4},
      '{{5'd5,5'd2,5'd0,17'h200}, {5'd1,5'd3,5'd2,17'h4}, {5'd3,5'd3,5'd0,17'h300}, STOPW, STOPW, 32'h300, 32'hCAFE0001, 8'd6},
      '{{5'd5,5'd2,5'd0,17'h208}, {5'd1,5'd3,5'd2,17'h1FFF8}, {5'd3,5'd3,5'd0,17'h300}, STOPW, STOPW, 32'h300, 32'h12345678, 8'd6},
      '{{5'd5,5'd1,5'd0,17'h5}, {5'd5,5'd2,5'd0,17'h1FFFD}, {5'd12,5'd4,5'd1,5'd2,12'h0}, {5'd3,5'd4,5'd0,17'h300}, STOPW, 32'h300, 32'h2, 8'd6},
      '{{5'd6,5'd5,22'h10}, {5'd3,5'd5,5'd0,17'h300}, STOPW, STOPW, STOPW, 32'h300, 32'h14, 8'd4},
      '{{5'd2,5'd6,22'h1FC}, {5'd3,5'd6,5'd0,17'h300}, STOPW, STOPW, STOPW, 32'h300, 32'h12345678, 8'd5},
      '{{5'd5,5'd7,5'd0,17'h77}, {5'd4,5'd7,22'h2F8}, STOPW, STOPW, STOPW, 32'h300, 32'h77, 8'd4},
      '{{5'd5,5'd1,5'd0,17'h55}, {5'd9,5'd1,5'd1,17'h1}, 32'h0, {5'd3,5'd1,5'd0,17'h300}, STOPW, 32'h300, 32'h55, 8'd6},
      '{{5'd5,5'd0,5'd0,17'h10}, {5'd5,5'd1,5'd0,17'h40}, {5'd3,5'd1,5'd0,17'h2F0}, STOPW, STOPW, 32'h2F0, 32'h40, 8'd5},
      '{{5'd5,5'd2,5'd0,17'h310}, {5'd5,5'd3,5'd0,17'h9}, {5'd3,5'd3,5'd2,17'h1FFF0}, STOPW, STOPW, 32'h300, 32'h9, 8'd5}
   };

   function automatic string vec_tag(int v);
      case (v)
         0: return "R8";
         1: return "R4";
         2: return "R4";
         3: return "R9";
         4: return "R6";
         5: return "R6";
         6: return "R7";
         7: return "R11";
         8: return "R5";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      nacc = 0;
      rst_n = 1'b1;
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = '0;
      mem[32'h200 >> 2] = 32'h12345678;
      mem[32'h204 >> 2] = 32'hCAFE0001;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_halt();
      for (int i = 0; i < 2000; i++) begin
         if (!running) break;
         @(negedge clk);
      end
   endtask

   task automatic run_vec(input int v);
      do_reset();
      clear_mem();
      mem[0] = VECS[v].i0;
      mem[1] = VECS[v].i1;
      mem[2] = VECS[v].i2;
      mem[3] = VECS[v].i3;
      mem[4] = VECS[v].i4;
      pulse_start();
      wait_halt();
      check(mem[VECS[v].chk[9:2]] == VECS[v].expv, vec_tag(v), mem[VECS[v].chk[9:2]], VECS[v].expv);
      check(nacc == int'(VECS[v].nacc), vec_tag(v), nacc, VECS[v].nacc);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset();
      clear_mem();
      repeat (4) @(negedge clk);
      check(running == 1'b0, "R1", running, 0);
      check(mem_req == 1'b0, "R1", mem_req, 0);
      check(nacc == 0, "R1", nacc, 0);

      // R2, R3, R10: start, sequential fetch, stop and resume
      mem[0] = 32'h0; mem[1] = 32'h0; mem[2] = 32'h0; mem[3] = STOPW;
      mem[4] = 32'h0; mem[5] = STOPW;
      pulse_start();
      check(running == 1'b1, "R2", running, 1);
      check(mem_req && !mem_we && mem_addr == 32'h0, "R2", mem_addr, 32'h0);
      wait_halt();
      check(nacc == 4, "R3", nacc, 4);
      for (int k = 0; k < 4; k++)
         check(log_addr[k] == 32'(4 * k) && !log_we[k], "R3", log_addr[k], 32'(4 * k));
      repeat (5) @(negedge clk);
      check(!running && !mem_req && nacc == 4, "R10", nacc, 4);
      pulse_start();
      wait_halt();
      check(nacc == 6, "R10", nacc, 6);
      check(log_addr[4] == 32'h10, "R10", log_addr[4], 32'h10);

      // Vector table
      for (int v = 0; v < 10; v++) begin
         lat = v % 3;
         run_vec(v);
      end

      // R12: slow memory
      lat = 3;
      run_vec(1);
      lat = 2;
      run_vec(6);
      lat = 0;

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule